// File: doc/BRIEF.md
# Omega Multistage Switching Network

This block connects a set of requesters (for example processors) to the same number of targets (for example memory banks). It does this through a chain of identical columns of two-by-two switches, one column for each address bit. Before each column the lines are re-ordered by a perfect shuffle. Each switch element is either straight or crossed, and the bits of the request's destination label set it. The network costs far fewer switch elements than a full crossbar. The price is that two requests can need the same internal line in the same cycle. When that happens one of them is refused.

On every cycle each requester may present a request, made of a valid flag, a destination label and a payload. The network works out a complete routing in one combinational pass. It registers the outcome. One cycle later, each target port shows whether it received a request, which requester it came from, and the payload. For every requester that lost a contention, a per-requester refusal flag is raised. Refused requests are dropped, and the requester decides whether to retry.

Top module: `omega_net`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every output is zero: no target valid, no refusal flag, zero source index and zero payload.
- R2: A request presented in cycle n appears in cycle n+1 on target port `dest`. That port's `out_valid` is 1, its `out_src` equals the requester index and its `out_data` equals the payload. Target ports without a delivery show valid 0, source 0 and payload 0.
- R3: A request presented with no other request active is always delivered to its destination, for every requester and destination pair.
- R4: When every requester is valid and requester i targets (i + c) mod PORTS, for any constant c, all PORTS requests are delivered and none is refused.
- R5: With 8 ports, requester 2 to target 7 and requester 6 to target 4 need the same internal line. Requester 2 is delivered and requester 6 is refused.
- R6: Every valid request is either delivered on exactly one target port or refused, never both. An invalid request is neither delivered nor refused.
- R7: When several requests name the same target, at most one of them is delivered and all others are refused.
- R8: Routing rule. Before column k (k = 0 first), line i moves to line rotate-left-by-one(i) over LG = log2(PORTS) bits. Switch element j of column k takes lines 2j (upper) and 2j+1 (lower). It sends a request to line 2j + b, where b is bit (LG-1-k) of the request's destination. If both inputs want the same output, the request on the upper input wins and the other is refused.
- R9: PORTS is a power of two of at least 2. There are log2(PORTS) switch columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | PORTS | Request present, one bit per requester |
| in_dest | input | PORTS x LG | Destination target index per requester |
| in_data | input | PORTS x DW | Payload per requester |
| out_valid | output | PORTS | A request was delivered, one bit per target |
| out_src | output | PORTS x LG | Requester index of the delivered request per target |
| out_data | output | PORTS x DW | Delivered payload per target |
| in_blocked | output | PORTS | Request of that requester was refused |

## Verification
The bench builds two copies of the network. The first has eight ports and three switch columns. This size contains the documented collision and enough lines for every requester/target pair, every cyclic shift and a full many-to-one pile-up to be run exhaustively. The second has two ports and a single column. There the shuffle is the identity, and the only contention is inside one switch element, which exercises the degenerate end of the log2 parameter range. Random request masks and labels on both copies exercise mixed partial contention.

// File: rtl/omega_net.sv
module omega_net #(
  parameter int PORTS = 8,
  parameter int DW    = 8,
  localparam int LG   = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PORTS-1:0]             in_valid,
  input  logic [PORTS-1:0][LG-1:0]     in_dest,
  input  logic [PORTS-1:0][DW-1:0]     in_data,
  output logic [PORTS-1:0]             out_valid,
  output logic [PORTS-1:0][LG-1:0]     out_src,
  output logic [PORTS-1:0][DW-1:0]     out_data,
  output logic [PORTS-1:0]             in_blocked
);

  initial assert_ports_pow2_R9: assert (PORTS >= 2 && (PORTS & (PORTS - 1)) == 0)
    else $error("PORTS must be a power of two, at least 2");

  function automatic logic [LG-1:0] shuffle(input logic [LG-1:0] x);
    logic [LG-1:0] r;
    for (int b = 0; b < LG; b++) r[(b + 1) % LG] = x[b];
    return r;
  endfunction

  logic [PORTS-1:0]    lv, sv, blk;
  logic [LG-1:0]       ls [PORTS];
  logic [LG-1:0]       ss [PORTS];
  logic                bu, bl;

  always_comb begin
    lv  = in_valid;
    blk = '0;
    bu  = 1'b0;
    bl  = 1'b0;
    for (int i = 0; i < PORTS; i++) ls[i] = LG'(i);
    for (int i = 0; i < PORTS; i++) ss[i] = '0;
    sv = '0;
    for (int k = 0; k < LG; k++) begin
      for (int i = 0; i < PORTS; i++) begin
        sv[shuffle(LG'(i))] = lv[i];
        ss[shuffle(LG'(i))] = ls[i];
      end
      for (int j = 0; j < PORTS / 2; j++) begin
        bu = in_dest[ss[2*j]][LG-1-k];
        bl = in_dest[ss[2*j+1]][LG-1-k];
        lv[2*j]   = 1'b0;
        lv[2*j+1] = 1'b0;
        ls[2*j]   = ss[2*j];
        ls[2*j+1] = ss[2*j+1];
        if (sv[2*j]) begin
          lv[2*j + int'(bu)] = 1'b1;
          ls[2*j + int'(bu)] = ss[2*j];
        end
        if (sv[2*j+1]) begin
          if (sv[2*j] && bu == bl) begin
            blk[ss[2*j+1]] = 1'b1;
          end else begin
            lv[2*j + int'(bl)] = 1'b1;
            ls[2*j + int'(bl)] = ss[2*j+1];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= '0;
      out_src    <= '0;
      out_data   <= '0;
      in_blocked <= '0;
    end else begin
      out_valid  <= lv;
      in_blocked <= blk;
      for (int d = 0; d < PORTS; d++) begin
        out_src[d]  <= lv[d] ? ls[d] : '0;
        out_data[d] <= lv[d] ? in_data[ls[d]] : '0;
      end
    end
  end

  assert_conserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(out_valid) + $countones(in_blocked) == $countones($past(in_valid))));

  assert_lone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(in_valid) == 1) |=> (in_blocked == '0 && $countones(out_valid) == 1));

  for (genvar g = 0; g < PORTS; g++) begin : g_chk
    assert_not_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[g] |-> !in_blocked[out_src[g]]);
    assert_blk_had_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      in_blocked[g] |-> $past(in_valid[g]));
    assert_src_was_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[g] |-> |(($past(in_valid) >> out_src[g]) & PORTS'(1)));
  end

endmodule

// File: tb/sim_omega_net.sv
`timescale 1ns/1ps
module sim_omega_net;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]       v8 = '0, ov8, bk8;
  logic [7:0][2:0]  d8 = '0, os8;
  logic [7:0][7:0]  p8 = '0, od8;
  logic [1:0]       v2 = '0, ov2, bk2;
  logic [1:0][0:0]  d2 = '0, os2;
  logic [1:0][7:0]  p2 = '0, od2;

  omega_net #(.PORTS(8), .DW(8)) u0 (.clk(clk), .rst_n(rst_n), .in_valid(v8), .in_dest(d8),
    .in_data(p8), .out_valid(ov8), .out_src(os8), .out_data(od8), .in_blocked(bk8));
  omega_net #(.PORTS(2), .DW(8)) u1 (.clk(clk), .rst_n(rst_n), .in_valid(v2), .in_dest(d2),
    .in_data(p2), .out_valid(ov2), .out_src(os2), .out_data(od2), .in_blocked(bk2));

  int checks = 0, errors = 0;
  int mv[8], md[8], mp[8];
  int ev[8], es[8], eb[8];

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // expected routing from the rule in R8
  task automatic model(int p, int lg);
    int cv[8], cs[8], nv[8], ns[8];
    for (int i = 0; i < p; i++) begin cv[i] = mv[i]; cs[i] = i; eb[i] = 0; end
    for (int k = 0; k < lg; k++) begin
      for (int i = 0; i < p; i++) begin
        int r = ((i << 1) | (i >> (lg - 1))) & (p - 1);
        nv[r] = cv[i]; ns[r] = cs[i];
      end
      for (int j = 0; j < p / 2; j++) begin
        int bu = (md[ns[2*j]] >> (lg - 1 - k)) & 1;
        int bl = (md[ns[2*j+1]] >> (lg - 1 - k)) & 1;
        cv[2*j] = 0; cv[2*j+1] = 0;
        if (nv[2*j] != 0) begin cv[2*j+bu] = 1; cs[2*j+bu] = ns[2*j]; end
        if (nv[2*j+1] != 0) begin
          if (nv[2*j] != 0 && bu == bl) eb[ns[2*j+1]] = 1;
          else begin cv[2*j+bl] = 1; cs[2*j+bl] = ns[2*j+1]; end
        end
      end
    end
    for (int d = 0; d < p; d++) begin ev[d] = cv[d]; es[d] = cv[d] ? cs[d] : 0; end
  endtask

  task automatic run(int big, string tag);
    int p = big ? 8 : 2;
    model(p, big ? 3 : 1);
    for (int i = 0; i < p; i++) begin
      if (big) begin v8[i] = mv[i][0]; d8[i] = 3'(md[i]); p8[i] = 8'(mp[i]); end
      else begin v2[i] = mv[i][0]; d2[i] = 1'(md[i]); p2[i] = 8'(mp[i]); end
    end
    @(posedge clk);
    @(negedge clk);
    for (int d = 0; d < p; d++) begin
      check(tag, $sformatf("valid[%0d]", d), big ? int'(ov8[d]) : int'(ov2[d]), ev[d]);
      check(tag, $sformatf("src[%0d]", d), big ? int'(os8[d]) : int'(os2[d]), es[d]);
      check(tag, $sformatf("data[%0d]", d), big ? int'(od8[d]) : int'(od2[d]),
            ev[d] ? (mp[es[d]] & 255) : 0);
    end
    for (int s = 0; s < p; s++)
      check(tag, $sformatf("blocked[%0d]", s), big ? int'(bk8[s]) : int'(bk2[s]), eb[s]);
  endtask

  task automatic clear();
    for (int i = 0; i < 8; i++) begin mv[i] = 0; md[i] = 0; mp[i] = 0; end
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    v8 = '1; v2 = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held at zero during reset
    check("R1", "out_valid8", int'(ov8), 0);
    check("R1", "blocked8", int'(bk8), 0);
    check("R1", "out_valid2", int'(ov2), 0);
    check("R1", "out_data8", int'(od8[0]), 0);
    v8 = '0; v2 = '0;
    rst_n = 1'b1;
    check("R1", "after release", int'(ov8) | int'(bk8), 0);

    // R3: lone request, every pair
    for (int s = 0; s < 8; s++)
      for (int t = 0; t < 8; t++) begin
        clear(); mv[s] = 1; md[s] = t; mp[s] = 8'hA0 + s * 8 + t;
        run(1, "R3 R2");
        check("R3", "delivered at dest", int'(ov8[t]), 1);
      end
    for (int s = 0; s < 2; s++)
      for (int t = 0; t < 2; t++) begin
        clear(); mv[s] = 1; md[s] = t; mp[s] = 8'h30 + s * 2 + t;
        run(0, "R3 R9");
      end

    // R4: cyclic shifts pass without refusal
    for (int c = 0; c < 8; c++) begin
      clear();
      for (int i = 0; i < 8; i++) begin mv[i] = 1; md[i] = (i + c) % 8; mp[i] = 16 * c + i; end
      run(1, "R4");
      check("R4", "delivered count", $countones(ov8), 8);
      check("R4", "refused count", $countones(bk8), 0);
    end

    // R5: documented collision
    clear(); mv[2] = 1; md[2] = 7; mp[2] = 8'h5A; mv[6] = 1; md[6] = 4; mp[6] = 8'hC3;
    run(1, "R5 R8");
    check("R5", "target7 valid", int'(ov8[7]), 1);
    check("R5", "target7 src", int'(os8[7]), 2);
    check("R5", "target4 valid", int'(ov8[4]), 0);
    check("R5", "src6 refused", int'(bk8[6]), 1);
    check("R5", "src2 refused", int'(bk8[2]), 0);

    // R7: all requesters to one target
    for (int t = 0; t < 8; t += 5) begin
      clear();
      for (int i = 0; i < 8; i++) begin mv[i] = 1; md[i] = t; mp[i] = i + 1; end
      run(1, "R7");
      check("R7", "delivered count", $countones(ov8), 1);
      check("R7", "refused count", $countones(bk8), 7);
    end
    clear(); mv[0] = 1; mv[1] = 1; md[0] = 1; md[1] = 1; mp[0] = 9; mp[1] = 10;
    run(0, "R7 R8");
    check("R7", "p2 winner", int'(os2[1]), 0);
    check("R7", "p2 refused", int'(bk2[1]), 1);

    // R6: idle cycle delivers and refuses nothing
    clear(); run(1, "R6"); run(0, "R6");

    // random mixes
    for (int n = 0; n < 400; n++) begin
      clear();
      for (int i = 0; i < 8; i++) begin
        mv[i] = ($urandom % 3 != 0) ? 1 : 0; md[i] = $urandom % 8; mp[i] = $urandom % 256;
      end
      run(1, "R2 R6 R8");
      check("R6", "conservation", $countones(ov8) + $countones(bk8), $countones(v8));
    end
    for (int n = 0; n < 60; n++) begin
      clear();
      for (int i = 0; i < 2; i++) begin
        mv[i] = $urandom % 2; md[i] = $urandom % 2; mp[i] = $urandom % 256;
      end
      run(0, "R2 R6 R8 R9");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule